// File: doc/BRIEF.md
# Banked Strided Vector Load Unit

This block loads one vector of words from a word-addressed memory split into several independent banks, and puts them into a vector register buffer. A request carries a base word address, a signed stride in words and a vector length. Element i is read from word address base + i*stride. The low bits of that address pick the bank and the remaining bits pick the row inside the bank. Every bank is given its own row address. Successive elements can therefore land anywhere in memory, and they do not have to be consecutive.

At most one element is issued per clock, in element order. An element is issued only if its bank is free. A bank that has just been read stays occupied for a fixed number of cycles. If the bank of the next element is still occupied, issue stalls, and the following elements wait behind it. Every access takes the same fixed start-up latency from issue to writeback. Because of this, words come back in element order without any reordering, tagged with their element index. A one-cycle done pulse follows the final writeback. After that, the buffer can be read through a small read port.

The banks hold their data in internal arrays. A word-addressed fill port loads those arrays before a load runs.

Top module: `strided_vload`

## Requirements
- R1: A request is accepted only while `idle` is high and `req_len` is between 1 and 64. `idle` is low from the cycle after acceptance until the cycle in which `done` is high. A request seen while the unit is busy, or one with length 0, changes nothing.
- R2: Element i reads word address (base + i*stride) mod 1024. The stride is an 8-bit two's-complement word count. The bank is address bits [2:0] and the row is bits [9:3].
- R3: A bank read in cycle t accepts its next read no earlier than cycle t+4.
- R4: Element 0 issues in the first cycle after acceptance. Element i issues in the later of two cycles: the cycle after element i-1 issued, and the first cycle its bank is free.
- R5: The word of each element appears on `wb_data`, with `wb_valid` high and `wb_idx` equal to the element index, exactly 12 cycles after its issue cycle. Elements appear in strictly increasing index order.
- R6: `done` is high for exactly one cycle: the cycle after the last element's writeback. `idle` is high in that same cycle.
- R7: With stride 0, each element after the first issues exactly 4 cycles after the one before it.
- R8: After `done`, driving `vreg_raddr` = i returns the word of element i on `vreg_rdata` one cycle later.
- R9: When `fill_en` is high, `fill_data` is written to word address `fill_addr`, in bank `fill_addr[2:0]` at row `fill_addr[9:3]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request strobe |
| req_base | input | 10 | Base word address |
| req_stride | input | 8 | Signed stride in words |
| req_len | input | 7 | Vector length, 1 to 64 |
| idle | output | 1 | Unit can accept a request |
| fill_en | input | 1 | Memory fill write strobe |
| fill_addr | input | 10 | Memory fill word address |
| fill_data | input | 32 | Memory fill word |
| wb_valid | output | 1 | Writeback of one element this cycle |
| wb_idx | output | 6 | Element index of the writeback |
| wb_data | output | 32 | Word written back |
| done | output | 1 | One-cycle pulse after the last writeback |
| vreg_raddr | input | 6 | Vector buffer read index |
| vreg_rdata | output | 32 | Vector buffer read word, one cycle latency |

## Verification
Assertions check the following on every cycle:
- a bank is never read while it is occupied, and it stays occupied after a read;
- a zero-stride run never issues on two consecutive cycles;
- writebacks carry consecutive indices;
- `done` is a single pulse that follows a writeback;
- a request with a bad length leaves the unit idle.

Some behaviour can only be shown by the bench scenarios. These include the exact issue schedule under bank collisions, the 12-cycle start-up latency and the data fetched for wrapped and negative strides. The bench computes each of these from its own model of bank occupancy and compares the cycle of `done` and every returned word against it.

// File: rtl/vload_pkg.sv
package vload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2
  } vld_state_e;
endpackage

// File: rtl/vload_bank.sv
module vload_bank #(
  parameter int DATA_W = 32,
  parameter int ROW_W  = 7,
  parameter int BUSY   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc,
  input  logic [ROW_W-1:0]  row,
  input  logic              fill_en,
  input  logic [ROW_W-1:0]  fill_row,
  input  logic [DATA_W-1:0] fill_data,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** ROW_W;
  localparam int CNT_W = $clog2(BUSY + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  occ_cnt;

  // simple dual-port array: fill writes, element reads with registered output
  always_ff @(posedge clk) begin
    if (fill_en) mem[fill_row] <= fill_data;
    if (acc) rd_data <= mem[row];
  end

  // occupancy counter: a read holds the bank for BUSY cycles
  always_ff @(posedge clk) begin
    if (rst) occ_cnt <= '0;
    else if (acc) occ_cnt <= CNT_W'(BUSY - 1);
    else if (occ_cnt != '0) occ_cnt <= occ_cnt - CNT_W'(1);
  end

  assign busy = (occ_cnt != '0);

  AST_BANK_REACCESS: assert property (@(posedge clk) disable iff (rst)
    acc |-> !busy); // R3

  generate
    if (BUSY > 1) begin : g_hold
      AST_BANK_HOLD: assert property (@(posedge clk) disable iff (rst)
        acc |=> busy); // R3
    end
  endgenerate
endmodule

// File: rtl/vload_agen.sv
module vload_agen import vload_pkg::*; #(
  parameter int ADDR_W    = 10,
  parameter int STRIDE_W  = 8,
  parameter int NBANK     = 8,
  parameter int MAX_VL    = 64,
  parameter int BANK_BUSY = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           req_valid,
  input  logic [ADDR_W-1:0]              req_base,
  input  logic [STRIDE_W-1:0]            req_stride,
  input  logic [$clog2(MAX_VL+1)-1:0]    req_len,
  input  logic [NBANK-1:0]               bank_busy,
  input  logic                           wb_last,
  output logic                           idle,
  output logic                           issue,
  output logic [$clog2(NBANK)-1:0]       iss_bank,
  output logic [ADDR_W-$clog2(NBANK)-1:0] iss_row,
  output logic [$clog2(MAX_VL)-1:0]      iss_idx,
  output logic [$clog2(MAX_VL+1)-1:0]    run_len
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = $clog2(MAX_VL + 1);

  vld_state_e          state;
  logic [ADDR_W-1:0]   cur_addr;
  logic [STRIDE_W-1:0] stride_q;
  logic [VL_W-1:0]     len_q;
  logic [IDX_W-1:0]    idx_q;
  logic [ADDR_W-1:0]   step;
  logic                accept;
  logic                len_ok;
  logic                last_el;

  assign step    = ADDR_W'($signed(stride_q));
  assign len_ok  = (req_len != '0) && (req_len <= VL_W'(MAX_VL));
  assign accept  = (state == ST_IDLE) && req_valid && len_ok;
  assign iss_bank = cur_addr[BANK_W-1:0];
  assign iss_row  = cur_addr[ADDR_W-1:BANK_W];
  assign iss_idx  = idx_q;
  assign issue    = (state == ST_ISSUE) && !bank_busy[iss_bank];
  assign last_el  = (VL_W'(idx_q) == len_q - VL_W'(1));
  assign idle     = (state == ST_IDLE);
  assign run_len  = len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      stride_q <= '0;
      len_q    <= '0;
      idx_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cur_addr <= req_base;
            stride_q <= req_stride;
            len_q    <= req_len;
            idx_q    <= '0;
            state    <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (issue) begin
            cur_addr <= cur_addr + step;
            idx_q    <= idx_q + IDX_W'(1);
            if (last_el) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: begin
          if (wb_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BAD_LEN_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && req_valid && !len_ok) |=> (state == ST_IDLE)); // R1

  generate
    if (BANK_BUSY > 1) begin : g_zero_gap
      AST_ZERO_STRIDE_GAP: assert property (@(posedge clk) disable iff (rst)
        (issue && stride_q == '0) |=> !issue); // R7
    end
  endgenerate
endmodule

// File: rtl/vload_retpipe.sv
module vload_retpipe #(
  parameter int DATA_W    = 32,
  parameter int NBANK     = 8,
  parameter int MAX_VL    = 64,
  parameter int START_LAT = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        issue,
  input  logic [$clog2(NBANK)-1:0]    iss_bank,
  input  logic [$clog2(MAX_VL)-1:0]   iss_idx,
  input  logic [$clog2(MAX_VL+1)-1:0] run_len,
  input  logic [NBANK*DATA_W-1:0]     bank_rd_flat,
  input  logic [$clog2(MAX_VL)-1:0]   vreg_raddr,
  output logic                        wb_valid,
  output logic [$clog2(MAX_VL)-1:0]   wb_idx,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        wb_last,
  output logic                        done,
  output logic [DATA_W-1:0]           vreg_rdata
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = $clog2(MAX_VL + 1);
  localparam int STG    = START_LAT - 1;

  // stage 0 runs alongside the bank's registered read
  logic              v0;
  logic [BANK_W-1:0] bank0;
  logic [IDX_W-1:0]  idx0;
  logic [DATA_W-1:0] sel_data;

  logic              sv   [STG];
  logic [IDX_W-1:0]  sidx [STG];
  logic [DATA_W-1:0] sdat [STG];

  logic [DATA_W-1:0] vreg [MAX_VL];
  logic [IDX_W-1:0]  ord_q;

  assign sel_data = bank_rd_flat[bank0*DATA_W +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst) v0 <= 1'b0;
    else v0 <= issue;
    bank0 <= iss_bank;
    idx0  <= iss_idx;
  end

  // fixed-length delay line keeps returns in issue order
  always_ff @(posedge clk) begin
    for (int k = 0; k < STG; k++) begin
      if (rst) sv[k] <= 1'b0;
      else if (k == 0) sv[k] <= v0;
      else sv[k] <= sv[k-1];
      if (k == 0) begin
        sidx[k] <= idx0;
        sdat[k] <= sel_data;
      end else begin
        sidx[k] <= sidx[k-1];
        sdat[k] <= sdat[k-1];
      end
    end
  end

  assign wb_valid = sv[STG-1];
  assign wb_idx   = sidx[STG-1];
  assign wb_data  = sdat[STG-1];
  assign wb_last  = wb_valid && (VL_W'(wb_idx) == run_len - VL_W'(1));

  always_ff @(posedge clk) begin
    if (wb_valid) vreg[wb_idx] <= wb_data;
    vreg_rdata <= vreg[vreg_raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else done <= wb_last;
  end

  // expected writeback index, kept only for the ordering check
  always_ff @(posedge clk) begin
    if (rst) ord_q <= '0;
    else if (wb_last) ord_q <= '0;
    else if (wb_valid) ord_q <= ord_q + IDX_W'(1);
  end

  AST_WB_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (wb_idx == ord_q)); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6

  AST_DONE_AFTER_WB: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(wb_valid)); // R6
endmodule

// File: rtl/strided_vload.sv
module strided_vload #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 10,
  parameter int STRIDE_W  = 8,
  parameter int NBANK     = 8,
  parameter int BANK_BUSY = 4,
  parameter int START_LAT = 12,
  parameter int MAX_VL    = 64
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req_valid,
  input  logic [ADDR_W-1:0]           req_base,
  input  logic [STRIDE_W-1:0]         req_stride,
  input  logic [$clog2(MAX_VL+1)-1:0] req_len,
  output logic                        idle,
  input  logic                        fill_en,
  input  logic [ADDR_W-1:0]           fill_addr,
  input  logic [DATA_W-1:0]           fill_data,
  output logic                        wb_valid,
  output logic [$clog2(MAX_VL)-1:0]   wb_idx,
  output logic [DATA_W-1:0]           wb_data,
  output logic                        done,
  input  logic [$clog2(MAX_VL)-1:0]   vreg_raddr,
  output logic [DATA_W-1:0]           vreg_rdata
);
  localparam int BANK_W = $clog2(NBANK);
  localparam int ROW_W  = ADDR_W - BANK_W;
  localparam int IDX_W  = $clog2(MAX_VL);
  localparam int VL_W   = $clog2(MAX_VL + 1);

  logic                    issue;
  logic [BANK_W-1:0]       iss_bank;
  logic [ROW_W-1:0]        iss_row;
  logic [IDX_W-1:0]        iss_idx;
  logic [VL_W-1:0]         run_len;
  logic [NBANK-1:0]        bank_busy;
  logic [NBANK*DATA_W-1:0] bank_rd_flat;
  logic                    wb_last;

  vload_agen #(
    .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .NBANK(NBANK),
    .MAX_VL(MAX_VL), .BANK_BUSY(BANK_BUSY)
  ) u_agen (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_base(req_base),
    .req_stride(req_stride), .req_len(req_len),
    .bank_busy(bank_busy), .wb_last(wb_last),
    .idle(idle), .issue(issue), .iss_bank(iss_bank),
    .iss_row(iss_row), .iss_idx(iss_idx), .run_len(run_len)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic acc_b;
      logic fill_b;
      assign acc_b  = issue && (iss_bank == BANK_W'(b));
      assign fill_b = fill_en && (fill_addr[BANK_W-1:0] == BANK_W'(b));

      vload_bank #(
        .DATA_W(DATA_W), .ROW_W(ROW_W), .BUSY(BANK_BUSY)
      ) u_bank (
        .clk(clk), .rst(rst),
        .acc(acc_b), .row(iss_row),
        .fill_en(fill_b), .fill_row(fill_addr[ADDR_W-1:BANK_W]),
        .fill_data(fill_data),
        .busy(bank_busy[b]),
        .rd_data(bank_rd_flat[b*DATA_W +: DATA_W])
      );
    end
  endgenerate

  vload_retpipe #(
    .DATA_W(DATA_W), .NBANK(NBANK), .MAX_VL(MAX_VL), .START_LAT(START_LAT)
  ) u_ret (
    .clk(clk), .rst(rst),
    .issue(issue), .iss_bank(iss_bank), .iss_idx(iss_idx),
    .run_len(run_len), .bank_rd_flat(bank_rd_flat),
    .vreg_raddr(vreg_raddr),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .wb_last(wb_last), .done(done), .vreg_rdata(vreg_rdata)
  );
endmodule

// File: tb/strided_vload_bench.sv
module strided_vload_bench;
  localparam int DW = 32, AW = 10, SW = 8, NB = 8, BUSY = 4, LAT = 12, MVL = 64;
  localparam int MEM = 2 ** AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [SW-1:0] req_stride = '0;
  logic [6:0] req_len = '0;
  logic idle;
  logic fill_en = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic wb_valid;
  logic [5:0] wb_idx;
  logic [DW-1:0] wb_data;
  logic done;
  logic [5:0] vreg_raddr = '0;
  logic [DW-1:0] vreg_rdata;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  typedef struct { int idx; logic [DW-1:0] dat; } item_t;
  item_t sbq[$];

  always #2.5 clk = ~clk;

  strided_vload #(
    .DATA_W(DW), .ADDR_W(AW), .STRIDE_W(SW), .NBANK(NB),
    .BANK_BUSY(BUSY), .START_LAT(LAT), .MAX_VL(MVL)
  ) u_strided_vload (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_base(req_base),
    .req_stride(req_stride), .req_len(req_len), .idle(idle),
    .fill_en(fill_en), .fill_addr(fill_addr), .fill_data(fill_data),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data), .done(done),
    .vreg_raddr(vreg_raddr), .vreg_rdata(vreg_rdata)
  );

  function automatic logic [DW-1:0] fdat(input int a);
    return 32'hC0DE0000 ^ (32'(a) * 32'h0001_0193);
  endfunction

  function automatic int wrap(input int a);
    return a & (MEM - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // monitor: pops the scoreboard on every writeback (R5)
  always @(posedge clk) begin
    #1;
    if (!rst && wb_valid) begin
      if (sbq.size() == 0) begin
        chk(1'b0, "R5", "unexpected writeback idx", wb_idx, 0);
      end else begin
        item_t e;
        e = sbq.pop_front();
        chk(wb_idx == 6'(e.idx), "R5", "writeback index", wb_idx, e.idx);
        chk(wb_data == e.dat, "R2", "writeback data", wb_data, e.dat);
      end
    end
  end

  task automatic run_vec(input int base, input int stride, input int len,
                         input bit poke, input string tag);
    int freeat[NB];
    int t_prev;
    int k;
    bit seen;
    for (int b = 0; b < NB; b++) freeat[b] = 0;
    t_prev = -1;
    // R4/R3 issue schedule model
    for (int i = 0; i < len; i++) begin
      int a = wrap(base + i * stride);
      int b = a % NB;
      int t = t_prev + 1;
      item_t it;
      if (freeat[b] > t) t = freeat[b];
      freeat[b] = t + BUSY;
      t_prev = t;
      it.idx = i;
      it.dat = fdat(a);
      sbq.push_back(it);
    end
    req_valid  = 1'b1;
    req_base   = AW'(base);
    req_stride = SW'(stride);
    req_len    = 7'(len);
    k = 0;
    seen = 1'b0;
    while (!seen && k < 4000) begin
      @(posedge clk); #1;
      k++;
      if (k == 1) begin
        req_valid = 1'b0;
        chk(idle == 1'b0, "R1", {tag, " idle after accept"}, idle, 0);
      end
      if (poke && k == 3) begin
        req_valid = 1'b1; req_base = AW'(base + 5); req_stride = 8'd3; req_len = 7'd5;
      end
      if (poke && k == 4) req_valid = 1'b0;
      if (done) seen = 1'b1;
    end
    // done cycle = last issue offset + start-up latency + 2 edges (R4, R5, R6)
    chk(k == t_prev + LAT + 2, "R4", {tag, " cycles to done"}, k, t_prev + LAT + 2);
    chk(idle == 1'b1, "R6", {tag, " idle with done"}, idle, 1);
    chk(sbq.size() == 0, "R5", {tag, " items left"}, sbq.size(), 0);
    @(posedge clk); #1;
    chk(done == 1'b0, "R6", {tag, " done one cycle"}, done, 0);
    for (int i = 0; i < len; i++) begin
      vreg_raddr = 6'(i);
      @(posedge clk); #1;
      chk(vreg_rdata == fdat(wrap(base + i * stride)), "R8", {tag, " vreg readback"},
          vreg_rdata, fdat(wrap(base + i * stride)));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(idle == 1'b1, "R1", "reset idle", idle, 1);
    chk(done == 1'b0, "R6", "reset done", done, 0);
    chk(wb_valid == 1'b0, "R5", "reset wb_valid", wb_valid, 0);
    rst = 1'b0;
    // R9: fill every word through the fill port
    for (int a = 0; a < MEM; a++) begin
      fill_en = 1'b1; fill_addr = AW'(a); fill_data = fdat(a);
      @(posedge clk); #1;
    end
    fill_en = 1'b0;
    @(posedge clk); #1;

    run_vec(16, 1, 64, 1'b0, "unit stride full length R4 R9");
    run_vec(3, 8, 10, 1'b0, "same bank stride R3");
    run_vec(100, 0, 6, 1'b0, "zero stride R7");
    run_vec(500, -3, 20, 1'b0, "negative stride R2");
    run_vec(7, 2, 16, 1'b0, "stride two no stall R4");
    run_vec(9, 4, 12, 1'b0, "two-bank stride R3");
    run_vec(1020, 5, 9, 1'b0, "address wrap R2");
    run_vec(42, 1, 1, 1'b0, "single element R6");
    run_vec(200, 3, 10, 1'b1, "request while busy R1");

    // R1: zero length request is ignored
    req_valid = 1'b1; req_base = 10'd5; req_stride = 8'd1; req_len = 7'd0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    for (int i = 0; i < 20; i++) begin
      chk(idle == 1'b1 && done == 1'b0 && wb_valid == 1'b0, "R1",
          "zero length ignored", {idle, done, wb_valid}, 3'b100);
      @(posedge clk); #1;
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule